// File: doc/BRIEF.md
# Multi-Select SPI Master

This block drives a four-wire serial peripheral bus from a small register-style host port. It shifts one word of `DW` bits per transfer in full duplex. Every bit sent on `mosi` is matched by one bit captured from `miso`. Clock polarity, clock phase and bit order are set at run time. One of up to three peripherals is chosen through its own active-low select line.

Software writes a control word and a divider value, then writes a transmit word. The master starts as soon as a peripheral is chosen and a word is pending. Because transmit holds a staging buffer separate from the shift register, the next word can be written while the current one is on the wire. A staged word is chained onto the current one without releasing the select. Each completed word sets a sticky interrupt. If a new word arrives before the previous one was read, an overrun flag records it.

The serial clock runs at the system clock divided by 2·(DIV+1). Each half period therefore lasts DIV+1 system cycles.

Top module: `spi_multi_master`

## Requirements
- R1: After reset every select line is high, `sclk` is low, `irq` is low and the status register (address 3) reads zero.
- R2: While no peripheral is selected, `sclk` rests at the polarity bit (control bit 0). During a word, `sclk` toggles exactly 2·DW times. Its period is 2·(DIV+1) system cycles, where DIV is the register at address 1.
- R3: With control bit 1 (phase) clear, the first data bit is on `mosi` when the select falls, bits are captured on leading clock edges and changed on trailing ones. With phase set, data changes on leading edges and is captured on trailing edges.
- R4: Control bit 2 picks the order on the wire: 0 sends and assembles bit DW-1 first, 1 sends and assembles bit 0 first.
- R5: The word captured from `miso` during a transfer is read back at address 2 once the transfer ends.
- R6: Control bits 4:3 pick the peripheral: value s in 1..3 drives `ss_n[s-1]` low for the whole transfer. Value 0 starts nothing. At most one select line is ever low.
- R7: A write to address 2 is staged while the empty buffer accepts it, and status bit 1 shows it pending. A write while a word is already staged is dropped.
- R8: A word staged when the current word finishes is sent next without the select going high in between.
- R9: Each completed word sets `irq` (status bit 3). It stays set until a write to address 3 with bit 3 set.
- R10: A word that completes while status bit 2 (unread data) is still set sets overrun (status bit 4) and replaces the stored word. Reading address 2 clears bit 2. A write to address 3 with bit 4 set clears overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (consumes received data at address 2) |
| addr | input | 2 | Register address: 0 control, 1 divider, 2 data, 3 status |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr` |
| irq | output | 1 | Sticky completion interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low peripheral selects |

## Verification
The bench sweeps all four clock modes, both bit orders, every select line and three divider values. A behavioural peripheral model checks each word in both directions. A phase mix-up would make that model sample between transitions and see shifted words. An ignored order bit would reverse both the word on the wire and the word read back.

Clock edges and period are counted at the pins. A divider off by one, or a missing or extra edge, would show as a wrong count. Chained words are checked for an unbroken select, a dropped third write and the overrun flag. A design that released the select between words, or accepted a write over a staged word, would show as an extra select rise or a third word.

// File: rtl/spi_multi_master.sv
module spi_multi_master #(
  parameter int DW   = 8,
  parameter int DIVW = 8,
  parameter int NSS  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic [NSS-1:0]  ss_n
);
  localparam int SELW = $clog2(NSS + 1);
  localparam int CW   = $clog2(2 * DW + 2);
  localparam logic [CW-1:0] LAST = CW'(2 * DW);

  logic            cpol, cpha, lsb;
  logic [SELW-1:0] sel, cur;
  logic [DIVW-1:0] div, hcnt;
  logic [CW-1:0]   ecnt, nxt;
  logic            tog, busy;
  logic [DW-1:0]   txbuf, rxbuf, tx_sh, rx_sh;
  logic            tx_full, rx_full, ovr;

  function automatic logic [DW-1:0] rev(input logic [DW-1:0] v);
    for (int i = 0; i < DW; i++) rev[i] = v[DW-1-i];
  endfunction

  wire wr_ctl = wr_en && addr == 2'd0;
  wire wr_div = wr_en && addr == 2'd1;
  wire wr_dat = wr_en && addr == 2'd2;
  wire wr_st  = wr_en && addr == 2'd3;
  wire rd_dat = rd_en && addr == 2'd2;

  assign nxt = ecnt + 1'b1;
  wire tick    = busy && hcnt == div;
  wire edge_ev = tick && ecnt != LAST;
  wire samp    = edge_ev && (nxt[0] ^ cpha);
  wire shft    = edge_ev && !samp && nxt != CW'(1);
  wire done    = tick && ecnt == LAST;
  wire start   = !busy && tx_full && sel != '0;
  wire load    = start || (done && tx_full);

  assign sclk = cpol ^ tog;
  assign mosi = tx_sh[DW-1];
  assign irq  = irq_q;

  logic irq_q;

  genvar g;
  generate
    for (g = 0; g < NSS; g++) begin : g_sel
      assign ss_n[g] = !(busy && cur == SELW'(g + 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpol <= 1'b0; cpha <= 1'b0; lsb <= 1'b0; sel <= '0; div <= '0;
    end else begin
      if (wr_ctl) begin
        cpol <= wdata[0];
        cpha <= wdata[1];
        lsb  <= wdata[2];
        sel  <= wdata[3 +: SELW];
      end
      if (wr_div) div <= wdata[DIVW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cur <= '0; hcnt <= '0; ecnt <= '0; tog <= 1'b0;
      tx_sh <= '0; rx_sh <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      hcnt  <= '0;
      ecnt  <= '0;
      tog   <= 1'b0;
      tx_sh <= lsb ? rev(txbuf) : txbuf;
      if (!busy) cur <= sel;
    end else if (busy) begin
      hcnt <= tick ? '0 : hcnt + 1'b1;
      if (edge_ev) begin
        tog  <= ~tog;
        ecnt <= nxt;
      end
      if (shft) tx_sh <= {tx_sh[DW-2:0], 1'b0};
      if (samp) rx_sh <= {rx_sh[DW-2:0], miso};
      if (done) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txbuf <= '0; tx_full <= 1'b0; rxbuf <= '0; rx_full <= 1'b0;
      irq_q <= 1'b0; ovr <= 1'b0;
    end else begin
      if (load) tx_full <= 1'b0;
      else if (wr_dat && !tx_full) begin
        tx_full <= 1'b1;
        txbuf   <= wdata;
      end
      if (done) begin
        rxbuf   <= lsb ? rev(rx_sh) : rx_sh;
        rx_full <= 1'b1;
      end else if (rd_dat) rx_full <= 1'b0;
      if (done) irq_q <= 1'b1;
      else if (wr_st && wdata[3]) irq_q <= 1'b0;
      if (done && rx_full && !rd_dat) ovr <= 1'b1;
      else if (wr_st && wdata[4]) ovr <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: begin
        rdata[0] = cpol;
        rdata[1] = cpha;
        rdata[2] = lsb;
        rdata[3 +: SELW] = sel;
      end
      2'd1: rdata[DIVW-1:0] = div;
      2'd2: rdata = rxbuf;
      default: rdata[4:0] = {ovr, irq_q, rx_full, tx_full, busy};
    endcase
  end
endmodule

// File: rtl/spi_multi_master_chk.sv
module spi_multi_master_chk #(
  parameter int DW   = 8,
  parameter int NSS  = 3,
  parameter int SELW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSS-1:0]  ss_n,
  input logic            sclk,
  input logic            irq,
  input logic            cpol,
  input logic            busy,
  input logic            tx_full,
  input logic            rx_full,
  input logic [SELW-1:0] sel,
  input logic            wr_en,
  input logic [1:0]      addr,
  input logic [DW-1:0]   wdata
);
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ss_n) <= 1); // R6
  AST_BUSY_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(~ss_n) == 1); // R6
  AST_NO_SEL_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sel == '0) |=> &ss_n); // R6
  AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&ss_n && $past(&ss_n) && $stable(cpol)) |-> $stable(sclk)); // R2
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && addr == 2'd3 && wdata[3])) |=> irq); // R9
  AST_IRQ_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> rx_full); // R9
  AST_STAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && !tx_full) |=> (tx_full || busy)); // R7
endmodule

bind spi_multi_master spi_multi_master_chk #(.DW(DW), .NSS(NSS), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sclk(sclk), .irq(irq), .cpol(cpol),
  .busy(busy), .tx_full(tx_full), .rx_full(rx_full), .sel(sel),
  .wr_en(wr_en), .addr(addr), .wdata(wdata)
);

// File: tb/tb_spi_multi_master.sv
module tb_spi_multi_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, miso = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic irq, sclk, mosi;
  logic [2:0] ss_n;

  spi_multi_master #(.DW(8), .DIVW(8), .NSS(3)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sclk(sclk), .mosi(mosi),
    .miso(miso), .ss_n(ss_n)
  );

  always #2.5 clk = ~clk;

  int total = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // peripheral model
  logic b_cpol = 0, b_cpha = 0, b_lsb = 0;
  int b_div = 0;
  logic [7:0] s_words [0:15];
  logic [7:0] s_log [0:15];
  logic s_first [0:15];
  logic [7:0] s_tx, s_cap;
  int k = 0, s_widx = 0, s_rcnt = 0;
  wire any_sel = ~&ss_n;

  function automatic int pos(input int kk);
    return b_lsb ? kk : 7 - kk;
  endfunction

  always @(posedge any_sel) begin
    k = 0;
    s_tx = s_words[s_widx & 15];
    if (!b_cpha) miso = s_tx[pos(0)];
  end

  always @(sclk) begin
    if (any_sel) begin
      if ((sclk != b_cpol) != b_cpha) begin
        if (k == 0) s_first[s_rcnt & 15] = mosi;
        s_cap[pos(k)] = mosi;
        k++;
        if (k == 8) begin
          s_log[s_rcnt & 15] = s_cap;
          s_rcnt++;
          s_widx++;
          s_tx = s_words[s_widx & 15];
          k = 0;
        end
      end else begin
        miso = s_tx[pos(k)];
      end
    end
  end

  // pin monitor
  int cyc = 0, last_rise = 0, toggles = 0, per_bad = 0;
  int bad_multi = 0, bad_line = 0, ss_rise = 0, exp_line = 0;
  bit have_rise = 0, chk_period = 0;
  logic prev_sclk = 0, prev_any = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if ($countones(~ss_n) > 1) bad_multi++;
      if (any_sel && ss_n[exp_line] != 1'b0) bad_line++;
      if (prev_any && !any_sel) ss_rise++;
      if (any_sel && sclk != prev_sclk) toggles++;
      if (any_sel && sclk && !prev_sclk && chk_period) begin
        if (have_rise && cyc - last_rise != 2 * (b_div + 1)) per_bad++;
        last_rise = cyc;
        have_rise = 1;
      end
      if (!any_sel) have_rise = 0;
    end
    prev_sclk = sclk;
    prev_any  = any_sel;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] v;
    logic [1:0] sl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ss_n", ss_n, 3'b111);
    chk("R1 sclk", sclk, 0);
    chk("R1 irq", irq, 0);
    rd(2'd3, v);
    chk("R1 status", v, 0);

    for (int d = 0; d < 3; d++)
      for (int m = 0; m < 4; m++)
        for (int o = 0; o < 2; o++) begin
          int it;
          logic [7:0] tw, sw;
          it = d * 8 + m * 2 + o;
          tw = 8'(8'h3C + it * 29);
          sw = 8'(8'hC1 ^ (it * 53));
          b_cpol = m[1]; b_cpha = m[0]; b_lsb = o[0]; b_div = d;
          sl = 2'((it % 3) + 1);
          exp_line = int'(sl) - 1;
          wr(2'd1, 8'(d));
          wr(2'd0, {3'b000, sl, b_lsb, b_cpha, b_cpol});
          @(negedge clk);
          chk("R2 idle level", sclk, b_cpol);
          s_words[0] = sw; s_widx = 0; s_rcnt = 0;
          toggles = 0; per_bad = 0; chk_period = 1;
          wr(2'd2, tw);
          while (!irq) @(negedge clk);
          @(negedge clk);
          chk_period = 0;
          chk("R6 released", ss_n, 3'b111);
          chk("R3 word at peripheral", s_log[0], tw);
          chk("R4 first bit", s_first[0], b_lsb ? tw[0] : tw[7]);
          chk("R2 edge count", toggles, 16);
          chk("R2 period", per_bad, 0);
          chk("R2 rest level", sclk, b_cpol);
          rd(2'd2, v);
          chk("R5 received word", v, sw);
          rd(2'd3, v);
          chk("R9 irq bit", v[3], 1);
          chk("R10 no overrun", v[4], 0);
          wr(2'd3, 8'h18);
          @(negedge clk);
          chk("R9 irq cleared", irq, 0);
        end

    // no peripheral chosen
    b_cpol = 0; b_cpha = 0; b_lsb = 0; b_div = 0;
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h00);
    s_words[0] = 8'h5A; s_widx = 0; s_rcnt = 0;
    wr(2'd2, 8'h96);
    repeat (60) @(negedge clk);
    chk("R6 no select", ss_n, 3'b111);
    rd(2'd3, v);
    chk("R7 staged pending", v[1:0], 2'b10);
    exp_line = 1;
    wr(2'd0, 8'h10);
    while (!irq) @(negedge clk);
    chk("R6 chosen line", s_log[0], 8'h96);
    rd(2'd2, v);
    chk("R10 read clears", v, 8'h5A);
    rd(2'd3, v);
    chk("R10 unread bit low", v[2], 0);
    wr(2'd3, 8'h18);

    // chained words
    b_div = 1; exp_line = 2;
    wr(2'd1, 8'd1);
    wr(2'd0, 8'h18);
    s_words[0] = 8'h11; s_words[1] = 8'hE7; s_widx = 0; s_rcnt = 0;
    ss_rise = 0;
    wr(2'd2, 8'hA3);
    v = 8'h00;
    while (!v[0]) rd(2'd3, v);
    wr(2'd2, 8'h4C);
    rd(2'd3, v);
    chk("R7 second staged", v[1:0], 2'b11);
    wr(2'd2, 8'hFF);
    while (s_rcnt < 2) @(negedge clk);
    repeat (80) @(negedge clk);
    chk("R8 select held", ss_rise, 1);
    chk("R7 first word", s_log[0], 8'hA3);
    chk("R7 second word", s_log[1], 8'h4C);
    chk("R7 full write dropped", s_rcnt, 2);
    rd(2'd3, v);
    chk("R10 overrun set", v[4], 1);
    wr(2'd3, 8'h10);
    rd(2'd3, v);
    chk("R10 overrun cleared", v[4], 0);
    chk("R9 irq kept", v[3], 1);
    rd(2'd2, v);
    chk("R10 newest kept", v, 8'hE7);
    wr(2'd3, 8'h08);
    @(negedge clk);
    chk("R9 irq cleared", irq, 0);

    chk("R6 one select", bad_multi, 0);
    chk("R6 line", bad_line, 0);
    summary();
  end
endmodule